// File: doc/BRIEF.md
# Flash Read Responder with Mode Multiplexer

This block is the read side of a parallel NOR flash model. A separate command sequencer tracks the unlock cycles and tells this block which mode the flash is in. For every accepted bus read, the block picks what to return from one of four sources:

- the storage array, with bytes ordered little- or big-endian;
- the identification codes;
- a status byte whose bit 6 flips on each poll;
- a small computed query table that describes the geometry.

The block also keeps a direct-array flag. Any write clears it. It comes back on by itself after enough plain reads in read mode.

Reads use a valid/ready request stream and a valid/ready response stream. The response stage is a single register. A request is accepted when `req_valid` is high and `req_ready` is high. `req_ready` is high when the response register is empty, or when its word is being taken in the same cycle. Its data appears on `rsp_data` one clock after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response word is held unchanged and no new request is accepted. The storage array sits outside the block. The block puts the masked address on `arr_addr`, and in the same cycle it expects the four bytes starting at that address on `arr_data`.

Top module: `flash_read_responder`

## Requirements
- R1: A request accepted in cycle t gives `rsp_valid`=1 from cycle t+1. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_data` stays stable and `req_ready`=0.
- R2: In `seq_mode` 0 (read) and 1 (erase setup), the response is array data. `arr_data` lane k ([8k+7:8k]) holds the byte at address+k. `req_size` 0 returns lane 0. `req_size` 1 returns {lane1,lane0} when `big_endian`=0 and {lane0,lane1} when `big_endian`=1. `req_size` 2 or 3 returns {lane3,lane2,lane1,lane0} when `big_endian`=0 and {lane0,lane1,lane2,lane3} when `big_endian`=1.
- R3: The word offset used by the ID and query modes is `req_addr[7:0]` shifted right by 0, 1 or 2 for `DEV_BYTES` of 1, 2 or 4.
- R4: In `seq_mode` 2 (autoselect), offset 0 returns `id_code0`, offset 1 returns `id_code1`, and offset 2 returns 0. Each is zero-extended to 32 bits.
- R5: In autoselect, offset 0x0E returns `id_code2` and offset 0x0F returns `id_code3`. If the selected code equals 0x00FF, array data is returned instead. Every other offset also returns array data.
- R6: In `seq_mode` 3, 4 and 5 (busy: program, chip erase, sector erase), a read returns the status byte, and bit 6 of the status is then inverted exactly once per accepted read. A pulse on `st_load` loads `st_value` and takes priority over the toggle.
- R7: In `seq_mode` 6 (query), the table is read at the word offset, zero-extended. Its non-zero entries are:
  - 0x10..0x12 = 0x51, 0x52, 0x59;
  - 0x13 = 0x02;
  - 0x27 = log2 of the chip size in bytes;
  - 0x2C = 1;
  - 0x2D/0x2E = low/high byte of (`NUM_SECT`-1);
  - 0x2F/0x30 = bits [15:8]/[23:16] of `SECT_BYTES`.
  All other entries read 0.
- R8: In query mode, any offset at or above 0x52 returns 0.
- R9: A cycle with `wr_seen`=1 makes `rom_mode`=0 from the next cycle and clears the read counter.
- R10: With `rom_mode`=0, every accepted read in `seq_mode` 0 advances the counter. The read that takes it above `ROM_RETURN` (42) sets `rom_mode`=1 in the next cycle. Reads in any other mode do not count.
- R11: `seq_mode` 7 is invalid. A read in this mode returns array data, and `mode_reset` pulses high for one cycle after acceptance.
- R12: After reset, `rsp_valid`=0, `rom_mode`=1, `mode_reset`=0 and the status byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | read request present |
| req_ready | output | 1 | request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | byte address within the chip |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| big_endian | input | 1 | byte order for multi-byte array reads |
| seq_mode | input | 3 | mode from the command sequencer |
| wr_seen | input | 1 | a bus write happened this cycle |
| st_load | input | 1 | load the status byte |
| st_value | input | 8 | status value to load |
| id_code0 | input | 16 | first ID code |
| id_code1 | input | 16 | second ID code |
| id_code2 | input | 16 | third ID code, 0x00FF means absent |
| id_code3 | input | 16 | fourth ID code, 0x00FF means absent |
| arr_addr | output | ADDR_W | array lookup address |
| arr_data | input | 32 | four array bytes starting at arr_addr |
| rsp_valid | output | 1 | response word present |
| rsp_ready | input | 1 | consumer takes the response |
| rsp_data | output | 32 | response word |
| rom_mode | output | 1 | direct array mode flag |
| mode_reset | output | 1 | invalid mode seen, sequencer should return to read |

## Verification
The bench targets the boundary of the lazy return. A counter that is off by one moves the flag rise to read 42 or read 44. A design that counts reads outside read mode rises too early. A design that skips the clear on a write in mid-count rises early after that write.

It also stalls the response while the status byte is being polled. A design that toggles on every presented request, rather than on every accepted one, returns the wrong bit 6 on the next poll.

The ID fallback is tested with a code of exactly 0x00FF and with a normal code. A wrong compare returns 0x00FF instead of array data.

Query offsets at and above the table end, and both byte orders for two- and four-byte reads, catch swapped lanes and a table that is not bounded at its end.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

  typedef enum logic [2:0] {
    SQ_READ    = 3'd0,
    SQ_ERSETUP = 3'd1,
    SQ_AUTOSEL = 3'd2,
    SQ_PROG    = 3'd3,
    SQ_CHIPER  = 3'd4,
    SQ_SECTER  = 3'd5,
    SQ_QUERY   = 3'd6,
    SQ_BAD     = 3'd7
  } seq_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } rd_size_e;

  localparam logic [7:0] QTAB_LEN = 8'h52;
  localparam logic [7:0] TOGGLE_MASK = 8'h40;
  localparam logic [15:0] ID_ABSENT = 16'h00FF;

  function automatic logic mode_is_busy(seq_mode_e m);
    return (m == SQ_PROG) || (m == SQ_CHIPER) || (m == SQ_SECTER);
  endfunction

endpackage

// File: rtl/flrd_lane_pack.sv
module flrd_lane_pack
  import flrd_pkg::*;
(
  input  logic [31:0] lanes,
  input  rd_size_e    size,
  input  logic        big_endian,
  output logic [31:0] word
);
  logic [7:0] bt [4];

  for (genvar gi = 0; gi < 4; gi++) begin : g_split
    assign bt[gi] = lanes[8*gi +: 8];
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: word = {24'h0, bt[0]};
      SZ_HALF: word = big_endian ? {16'h0, bt[0], bt[1]} : {16'h0, bt[1], bt[0]};
      default: word = big_endian ? {bt[0], bt[1], bt[2], bt[3]}
                                 : {bt[3], bt[2], bt[1], bt[0]};
    endcase
  end
endmodule

// File: rtl/flrd_query_rom.sv
module flrd_query_rom
  import flrd_pkg::*;
#(
  parameter int SECT_BYTES = 4096,
  parameter int NUM_SECT   = 16
) (
  input  logic [7:0] offset,
  output logic [7:0] value
);
  localparam int          CHIP_BYTES = SECT_BYTES * NUM_SECT;
  localparam logic [7:0]  SIZE_LOG   = 8'($clog2(CHIP_BYTES));
  localparam logic [31:0] NM1_V      = 32'(NUM_SECT - 1);
  localparam logic [31:0] SECT_V     = 32'(SECT_BYTES);

  always_comb begin
    value = 8'h00;
    if (offset < QTAB_LEN) begin
      unique case (offset)
        8'h10:   value = 8'h51;
        8'h11:   value = 8'h52;
        8'h12:   value = 8'h59;
        8'h13:   value = 8'h02;
        8'h27:   value = SIZE_LOG;
        8'h2C:   value = 8'h01;
        8'h2D:   value = NM1_V[7:0];
        8'h2E:   value = NM1_V[15:8];
        8'h2F:   value = SECT_V[15:8];
        8'h30:   value = SECT_V[23:16];
        default: value = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flrd_status.sv
module flrd_status
  import flrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       poll,
  output logic [7:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    stat_q <= 8'h00;
    else if (load) stat_q <= load_val;
    else if (poll) stat_q <= stat_q ^ TOGGLE_MASK;
  end
endmodule

// File: rtl/flrd_rom_track.sv
module flrd_rom_track #(
  parameter int LIMIT = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_seen,
  input  logic plain_rd,
  output logic rom_q
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rom_q <= 1'b1;
    end else if (wr_seen) begin
      cnt_q <= '0;
      rom_q <= 1'b0;
    end else if (plain_rd && !rom_q) begin
      cnt_q <= cnt_nx;
      if (cnt_nx > CW'(LIMIT)) rom_q <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
  import flrd_pkg::*;
#(
  parameter int SECT_BYTES = 4096,
  parameter int NUM_SECT   = 16,
  parameter int DEV_BYTES  = 2,
  parameter int ROM_RETURN = 42,
  parameter int ADDR_W     = $clog2(SECT_BYTES * NUM_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              big_endian,
  input  logic [2:0]        seq_mode,
  input  logic              wr_seen,
  input  logic              st_load,
  input  logic [7:0]        st_value,
  input  logic [15:0]       id_code0,
  input  logic [15:0]       id_code1,
  input  logic [15:0]       id_code2,
  input  logic [15:0]       id_code3,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [31:0]       arr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rom_mode,
  output logic              mode_reset
);
  localparam int SHIFT = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;

  seq_mode_e   mode;
  logic        accept;
  logic [7:0]  word_off;
  logic [31:0] arr_word;
  logic [7:0]  qbyte;
  logic [7:0]  stat_q;
  logic [31:0] sel_data;

  assign mode      = seq_mode_e'(seq_mode);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign arr_addr  = req_addr;

  if (SHIFT == 0) begin : g_off_byte
    assign word_off = req_addr[7:0];
  end else begin : g_off_wide
    assign word_off = {{SHIFT{1'b0}}, req_addr[7:SHIFT]};
  end

  flrd_lane_pack u_pack (
    .lanes      (arr_data),
    .size       (rd_size_e'(req_size)),
    .big_endian (big_endian),
    .word       (arr_word)
  );

  flrd_query_rom #(
    .SECT_BYTES (SECT_BYTES),
    .NUM_SECT   (NUM_SECT)
  ) u_qrom (
    .offset (word_off),
    .value  (qbyte)
  );

  flrd_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (st_load),
    .load_val (st_value),
    .poll     (accept && mode_is_busy(mode)),
    .stat_q   (stat_q)
  );

  flrd_rom_track #(
    .LIMIT (ROM_RETURN)
  ) u_rom (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_seen  (wr_seen),
    .plain_rd (accept && (mode == SQ_READ)),
    .rom_q    (rom_mode)
  );

  always_comb begin
    sel_data = arr_word;
    unique case (mode)
      SQ_AUTOSEL: begin
        unique case (word_off)
          8'h00:   sel_data = {16'h0, id_code0};
          8'h01:   sel_data = {16'h0, id_code1};
          8'h02:   sel_data = 32'h0;
          8'h0E:   sel_data = (id_code2 == ID_ABSENT) ? arr_word : {16'h0, id_code2};
          8'h0F:   sel_data = (id_code3 == ID_ABSENT) ? arr_word : {16'h0, id_code3};
          default: sel_data = arr_word;
        endcase
      end
      SQ_PROG, SQ_CHIPER, SQ_SECTER: sel_data = {24'h0, stat_q};
      SQ_QUERY:                      sel_data = {24'h0, qbyte};
      default:                       sel_data = arr_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= 32'h0;
      mode_reset <= 1'b0;
    end else begin
      mode_reset <= accept && (mode == SQ_BAD);
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_data  <= sel_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flrd_checker.sv
module flrd_checker #(
  parameter int DEV_BYTES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [7:0]  addr_lo,
  input logic [2:0]  seq_mode,
  input logic        wr_seen,
  input logic        st_load,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        rom_mode,
  input logic        mode_reset,
  input logic [7:0]  stat_q
);
  localparam int SHIFT = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;

  logic       acc;
  logic       busy;
  logic [7:0] off;

  assign acc  = req_valid && req_ready;
  assign busy = (seq_mode == 3'd3) || (seq_mode == 3'd4) || (seq_mode == 3'd5);
  assign off  = addr_lo >> SHIFT;

  p_accept_gives_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_hold_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_no_accept_stalled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_toggle_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && busy && !st_load |=> stat_q == ($past(stat_q) ^ 8'h40));

  p_status_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && busy) && !st_load |=> $stable(stat_q));

  p_query_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (seq_mode == 3'd6) && (off >= 8'h52) |=> rsp_data == 32'h0);

  p_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen |=> !rom_mode);

  p_rom_rise_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_mode) |-> $past(acc && (seq_mode == 3'd0) && !wr_seen));

  p_bad_mode_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (seq_mode == 3'd7) |=> mode_reset);

  p_pulse_needs_bad_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reset |-> $past(acc && (seq_mode == 3'd7)));
endmodule

bind flash_read_responder flrd_checker #(.DEV_BYTES(DEV_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .addr_lo    (req_addr[7:0]),
  .seq_mode   (seq_mode),
  .wr_seen    (wr_seen),
  .st_load    (st_load),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rom_mode   (rom_mode),
  .mode_reset (mode_reset),
  .stat_q     (stat_q)
);

// File: tb/tb_flash_read_responder.sv
module tb_flash_read_responder;
  localparam int SECT = 4096;
  localparam int NSEC = 16;
  localparam int CHIP = SECT * NSEC;
  localparam int AW   = $clog2(CHIP);
  localparam int SH   = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd0;
  logic          big_endian = 1'b0;
  logic [2:0]    seq_mode = 3'd0;
  logic          wr_seen = 1'b0;
  logic          st_load = 1'b0;
  logic [7:0]    st_value = 8'h0;
  logic [15:0]   id_code0 = 16'h0001;
  logic [15:0]   id_code1 = 16'h227E;
  logic [15:0]   id_code2 = 16'h00FF;
  logic [15:0]   id_code3 = 16'h2201;
  logic [AW-1:0] arr_addr;
  logic [31:0]   arr_data;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_data;
  logic          rom_mode;
  logic          mode_reset;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] abyte(int a);
    int m;
    m = a & (CHIP - 1);
    return 8'((m * 37 + 11) & 255);
  endfunction

  assign arr_data = {abyte(int'(arr_addr) + 3), abyte(int'(arr_addr) + 2),
                     abyte(int'(arr_addr) + 1), abyte(int'(arr_addr))};

  flash_read_responder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .big_endian(big_endian),
    .seq_mode(seq_mode), .wr_seen(wr_seen), .st_load(st_load), .st_value(st_value),
    .id_code0(id_code0), .id_code1(id_code1), .id_code2(id_code2), .id_code3(id_code3),
    .arr_addr(arr_addr), .arr_data(arr_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rom_mode(rom_mode),
    .mode_reset(mode_reset)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    m_rv = 1'b0, m_rom = 1'b1, m_mr = 1'b0;
  int    m_cnt = 0;
  logic [7:0]  m_stat = 8'h0;
  logic [31:0] m_rd = 32'h0;
  string m_tag = "R1";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_array(int a, int sz, bit be);
    logic [7:0] b0, b1, b2, b3;
    b0 = abyte(a); b1 = abyte(a + 1); b2 = abyte(a + 2); b3 = abyte(a + 3);
    if (sz == 0) return {24'h0, b0};
    if (sz == 1) return be ? {16'h0, b0, b1} : {16'h0, b1, b0};
    return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  function automatic logic [7:0] exp_query(int off);
    if (off >= 'h52) return 8'h0;
    case (off)
      'h10: return 8'h51;
      'h11: return 8'h52;
      'h12: return 8'h59;
      'h13: return 8'h02;
      'h27: return 8'($clog2(CHIP));
      'h2C: return 8'h01;
      'h2D: return 8'((NSEC - 1) & 255);
      'h2E: return 8'((NSEC - 1) >> 8);
      'h2F: return 8'((SECT >> 8) & 255);
      'h30: return 8'((SECT >> 16) & 255);
      default: return 8'h0;
    endcase
  endfunction

  // Compare outputs with the model, apply new inputs, advance model one clock.
  task automatic step(input bit v, input int addr, input int sz, input bit be,
                      input int mode, input bit wr, input bit ld, input int ldv,
                      input bit rdy, input string tag);
    bit acc;
    int off;
    logic [31:0] val;
    chk(rsp_valid == m_rv, "R1 rsp_valid", 32'(rsp_valid), 32'(m_rv));
    chk(rom_mode == m_rom, "R9/R10 rom_mode", 32'(rom_mode), 32'(m_rom));
    chk(mode_reset == m_mr, "R11 mode_reset", 32'(mode_reset), 32'(m_mr));
    if (m_rv) chk(rsp_data == m_rd, m_tag, rsp_data, m_rd);
    chk(req_ready == (!m_rv || rsp_ready), "R1 req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));

    req_valid = v; req_addr = AW'(addr); req_size = 2'(sz); big_endian = be;
    seq_mode = 3'(mode); wr_seen = wr; st_load = ld; st_value = 8'(ldv); rsp_ready = rdy;

    acc = v && (!m_rv || rdy);
    off = (addr & 255) >> SH;
    val = exp_array(addr, sz, be);
    if (mode == 2) begin
      if (off == 0) val = {16'h0, id_code0};
      else if (off == 1) val = {16'h0, id_code1};
      else if (off == 2) val = 32'h0;
      else if (off == 'h0E && id_code2 != 16'h00FF) val = {16'h0, id_code2};
      else if (off == 'h0F && id_code3 != 16'h00FF) val = {16'h0, id_code3};
    end else if (mode >= 3 && mode <= 5) begin
      val = {24'h0, m_stat};
    end else if (mode == 6) begin
      val = {24'h0, exp_query(off)};
    end
    if (ld) m_stat = 8'(ldv);
    else if (acc && mode >= 3 && mode <= 5) m_stat = m_stat ^ 8'h40;
    if (wr) begin
      m_rom = 1'b0; m_cnt = 0;
    end else if (acc && mode == 0 && !m_rom) begin
      m_cnt++;
      if (m_cnt > 42) m_rom = 1'b1;
    end
    m_mr = acc && (mode == 7);
    if (acc) begin
      m_rd = val; m_tag = tag;
    end
    m_rv = acc ? 1'b1 : (rdy ? 1'b0 : m_rv);
    @(negedge clk);
  endtask

  task automatic rd(input int addr, input int sz, input bit be, input int mode, input string tag);
    step(1'b1, addr, sz, be, mode, 1'b0, 1'b0, 0, 1'b1, tag);
  endtask

  task automatic idle();
    step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b1, "R1 idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state
    chk(rsp_valid == 1'b0, "R12 rsp_valid", 32'(rsp_valid), 0);
    chk(rom_mode == 1'b1, "R12 rom_mode", 32'(rom_mode), 1);
    chk(mode_reset == 1'b0, "R12 mode_reset", 32'(mode_reset), 0);
    idle();
    rd('h40, 0, 0, 3, "R12 status zero after reset");
    idle();
    // R2: array reads in read mode and erase setup, all sizes and orders
    rd('h100, 0, 0, 0, "R2 byte");
    rd('h101, 1, 0, 0, "R2 half le");
    rd('h102, 1, 1, 0, "R2 half be");
    rd('h204, 2, 0, 0, "R2 word le");
    rd('h204, 2, 1, 0, "R2 word be");
    rd('hFFFE, 3, 1, 0, "R2 word wrap be");
    rd('h333, 2, 0, 1, "R2 erase setup le");
    rd('h334, 1, 1, 1, "R2 erase setup be");
    // R3/R4: autoselect id offsets (byte addr = offset*2)
    rd('h000, 1, 0, 2, "R4 id0 off0");
    rd('h002, 1, 0, 2, "R3 R4 id1 off1");
    rd('h303, 1, 0, 2, "R3 high addr bits ignored off1");
    rd('h004, 1, 0, 2, "R4 protect off2");
    // R5: fallback and codes
    rd('h01C, 1, 0, 2, "R5 id2 absent array");
    rd('h01E, 1, 0, 2, "R5 id3 present");
    rd('h006, 1, 1, 2, "R5 other offset array");
    idle();
    id_code2 = 16'h2210; id_code3 = 16'h00FF;
    rd('h01C, 1, 0, 2, "R5 id2 present");
    rd('h01E, 2, 0, 2, "R5 id3 absent array");
    // R6: status polling with stall
    step(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 'h08, 1'b1, "R6 load");
    rd('h10, 0, 0, 3, "R6 prog poll 1");
    rd('h10, 0, 0, 4, "R6 chip poll 2");
    step(1'b1, 'h10, 0, 1'b0, 5, 1'b0, 1'b0, 0, 1'b0, "R6 sect poll stalled");
    step(1'b1, 'h10, 0, 1'b0, 5, 1'b0, 1'b0, 0, 1'b0, "R1 R6 blocked poll");
    step(1'b1, 'h10, 0, 1'b0, 5, 1'b0, 1'b0, 0, 1'b0, "R1 R6 blocked poll");
    step(1'b0, 0, 0, 1'b0, 5, 1'b0, 1'b0, 0, 1'b1, "R1 release");
    rd('h10, 0, 0, 5, "R6 poll after stall");
    step(1'b1, 'h10, 0, 1'b0, 3, 1'b0, 1'b1, 'h80, 1'b1, "R6 load wins over toggle");
    rd('h10, 0, 0, 3, "R6 poll after load");
    // R7/R8: query table
    for (int o = 'h10; o <= 'h13; o++) rd(o * 2, 1, 0, 6, "R7 qry id");
    rd('h27 * 2, 1, 0, 6, "R7 size log");
    for (int o = 'h2C; o <= 'h30; o++) rd(o * 2, 1, 0, 6, "R7 region");
    rd('h05 * 2, 1, 0, 6, "R7 zero entry");
    rd('h51 * 2, 1, 0, 6, "R8 last entry");
    rd('h52 * 2, 1, 0, 6, "R8 at end");
    rd('h7F * 2, 1, 0, 6, "R8 far beyond");
    // R11: invalid mode
    rd('h456, 2, 1, 7, "R11 bad mode array");
    rd('h457, 0, 0, 0, "R2 after bad mode");
    idle();
    // R9/R10: lazy return
    step(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 0, 1'b1, "R9 write");
    for (int i = 0; i < 20; i++) rd(i, 0, 0, 0, "R10 counting");
    for (int i = 0; i < 6; i++) rd(i * 2, 1, 0, 2, "R10 other mode no count");
    step(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 0, 1'b1, "R9 write mid count");
    for (int i = 0; i < 42; i++) rd(i + 'h80, 0, 0, 0, "R10 below limit");
    idle(); idle();
    rd('h900, 0, 0, 0, "R10 forty-third read");
    idle();
    for (int i = 0; i < 5; i++) rd(i, 0, 0, 0, "R10 stays set");
    step(1'b1, 'h20, 0, 1'b0, 0, 1'b1, 1'b0, 0, 1'b1, "R9 write with read");
    idle(); idle();
    finish_run();
  end
endmodule